// File: doc/BRIEF.md
# Interlaced Raster Line Gate

This block follows the position of an interlaced 525-line raster. It watches a horizontal sync strobe and a vertical sync strobe, sampled on the pixel clock. From them it keeps a frame line number in the range 1 to 525 and a field identity. Once per line it produces a set of gating flags that later stages of a composite video encoder use: a vertical-blank flag, an active-video enable, a colour-burst enable, a closed-caption insert enable and a field indicator.

Static control bits set several things. They choose how deep the vertical blanking is at the top of each field. They pick which of the two caption lines may carry caption data. They can swap the field identities. They set the active edge of each sync input. Three test bits change the normal gating: one forces captions onto every line, one forces burst onto every line, and one removes all blanking and suppresses burst. Field phase comes from where the vertical strobe lands inside a line. A strobe in the first half of a line starts field 1. A strobe in the second half starts field 2.

Top module: `ntsc_line_gate`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released until the first active horizontal edge, all five outputs are 0. The line number is 0 (unsynchronised) and the field is field 1.
- R2: Each active horizontal edge advances the line number by one, and line 525 is followed by line 1. A vertical edge seen while the pixel count since the last horizontal edge is below `HALF_LINE` makes the next line 1. A vertical edge seen at or after that count makes the next line 263.
- R3: `field_o` is 0 on lines 1 to 262 and 1 on lines 263 to 525. When `field_swap` is 1, the value is inverted.
- R4: With `active_on` at 0, `vblank_o` is 1 on the first lines of each field and 0 on the rest. Field 2 counts from line 263. The blanked count is 9 lines when `wide_blank` is 0 and 15 lines when it is 1.
- R5: With `active_on` at 0, `active_en_o` is the inverse of `vblank_o`. With `active_on` at 1, `active_en_o` is 1 and `vblank_o` is 0 on every line.
- R6: `burst_en_o` is 1 on lines that are not blanked. When `burst_on` is 1, it is 1 on every line. When `active_on` is 1, it is 0 on every line; this takes priority over `burst_on`.
- R7: `caption_en_o` is 1 on line 21 when `cap_f1_en` is 1, and on line 284 when `cap_f2_en` is 1. When `cap_all` is 1, it is 1 on every line.
- R8: An edge on a sync input is active when it rises and the matching polarity bit (`hs_pol` or `vs_pol`) is 1, or when it falls and that bit is 0.
- R9: Outputs are registered and change only at an active horizontal edge. At that edge they describe the line that begins there. A control bit changed in the middle of a line has no effect until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync strobe |
| vsync_in | input | 1 | Vertical sync strobe |
| hs_pol | input | 1 | Horizontal active edge: 1 rising, 0 falling |
| vs_pol | input | 1 | Vertical active edge: 1 rising, 0 falling |
| wide_blank | input | 1 | 1: 15 blank lines per field, 0: 9 |
| cap_f1_en | input | 1 | Allow caption on line 21 |
| cap_f2_en | input | 1 | Allow caption on line 284 |
| cap_all | input | 1 | Test: caption enable on every line |
| burst_on | input | 1 | Test: burst on every line |
| active_on | input | 1 | Test: no blanking, no burst |
| field_swap | input | 1 | Exchange field identities |
| vblank_o | output | 1 | Line is vertically blanked |
| burst_en_o | output | 1 | Colour burst enable for the line |
| active_en_o | output | 1 | Active video enable for the line |
| caption_en_o | output | 1 | Caption insert enable for the line |
| field_o | output | 1 | 0 field 1, 1 field 2 (after swap) |

## Verification
The assertions assume three things. The polarity bits change only while reset is held. Each sync input rests at its inactive level after reset, so release does not look like an edge. The test bits are latched at horizontal edges, so the checker records `burst_on` at those edges rather than reading it live. The stimulus follows these rules. It changes polarity and idle levels only inside a reset window, and it changes configuration only at line boundaries, except for the single deliberate change in the middle of a line. Vertical strobes are placed well clear of the half-line threshold and never in the same cycle as a horizontal edge.

// File: rtl/ntsc_gate_pkg.sv
package ntsc_gate_pkg;

    typedef struct packed {
        logic vblank;
        logic burst;
        logic active;
        logic caption;
        logic field;
    } gate_flags_t;

    typedef struct packed {
        logic wide_blank;
        logic cap_f1_en;
        logic cap_f2_en;
        logic cap_all;
        logic active_on;
        logic burst_on;
        logic field_swap;
    } gate_cfg_t;

endpackage

// File: rtl/ntsc_sync_edge.sv
module ntsc_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic pol,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sync_in;
        edge_o = pol ? (sync_in & ~prev_q) : (~sync_in & prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/ntsc_line_track.sv
module ntsc_line_track #(
    parameter int LINES     = 525,
    parameter int F1_LINES  = 262,
    parameter int HALF_LINE = 429,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_edge,
    input  logic              vs_edge,
    output logic [LINE_W-1:0] line_next_o
);
    localparam int HCNT_W = $clog2(HALF_LINE + 1);
    localparam logic [HCNT_W-1:0] HCNT_MAX = HCNT_W'(HALF_LINE);
    localparam logic [LINE_W-1:0] F2_FIRST = LINE_W'(F1_LINES + 1);
    localparam logic [LINE_W-1:0] LAST     = LINE_W'(LINES);

    typedef struct packed {
        logic [HCNT_W-1:0] hcnt;
        logic              pend;
        logic              pend_f2;
        logic [LINE_W-1:0] line;
    } track_t;

    track_t st_d, st_q;
    logic   late_vs;

    always_comb begin
        st_d    = st_q;
        late_vs = (st_q.hcnt >= HCNT_MAX);
        if (hs_edge) begin
            st_d.hcnt = '0;
            st_d.pend = 1'b0;
            if (vs_edge)
                st_d.line = late_vs ? F2_FIRST : LINE_W'(1);
            else if (st_q.pend)
                st_d.line = st_q.pend_f2 ? F2_FIRST : LINE_W'(1);
            else if (st_q.line == LAST)
                st_d.line = LINE_W'(1);
            else
                st_d.line = st_q.line + LINE_W'(1);
        end else begin
            if (st_q.hcnt != HCNT_MAX)
                st_d.hcnt = st_q.hcnt + HCNT_W'(1);
            if (vs_edge) begin
                st_d.pend    = 1'b1;
                st_d.pend_f2 = late_vs;
            end
        end
        line_next_o = st_d.line;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/ntsc_line_decode.sv
module ntsc_line_decode
    import ntsc_gate_pkg::*;
#(
    parameter int F1_LINES   = 262,
    parameter int NARROW_VB  = 9,
    parameter int WIDE_VB    = 15,
    parameter int CAP_LINE_1 = 21,
    parameter int CAP_LINE_2 = 284,
    parameter int LINE_W     = 10
) (
    input  logic [LINE_W-1:0] line_i,
    input  gate_cfg_t         cfg_i,
    output gate_flags_t       flags_o
);
    localparam logic [LINE_W-1:0] F1_LAST = LINE_W'(F1_LINES);

    logic              in_f2;
    logic [LINE_W-1:0] fline;
    logic [LINE_W-1:0] depth;
    logic              in_blank;

    always_comb begin
        in_f2    = (line_i > F1_LAST);
        fline    = in_f2 ? (line_i - F1_LAST) : line_i;
        depth    = cfg_i.wide_blank ? LINE_W'(WIDE_VB) : LINE_W'(NARROW_VB);
        in_blank = (line_i != '0) && (fline <= depth);

        flags_o.vblank  = ~cfg_i.active_on & in_blank;
        flags_o.active  = cfg_i.active_on | ~in_blank;
        flags_o.burst   = ~cfg_i.active_on & (cfg_i.burst_on | ~in_blank);
        flags_o.caption = cfg_i.cap_all
                        | (cfg_i.cap_f1_en & (line_i == LINE_W'(CAP_LINE_1)))
                        | (cfg_i.cap_f2_en & (line_i == LINE_W'(CAP_LINE_2)));
        flags_o.field   = in_f2 ^ cfg_i.field_swap;
    end
endmodule

// File: rtl/ntsc_line_gate.sv
module ntsc_line_gate
    import ntsc_gate_pkg::*;
#(
    parameter int LINES      = 525,
    parameter int F1_LINES   = 262,
    parameter int HALF_LINE  = 429,
    parameter int NARROW_VB  = 9,
    parameter int WIDE_VB    = 15,
    parameter int CAP_LINE_1 = 21,
    parameter int CAP_LINE_2 = 284
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic hs_pol,
    input  logic vs_pol,
    input  logic wide_blank,
    input  logic cap_f1_en,
    input  logic cap_f2_en,
    input  logic cap_all,
    input  logic burst_on,
    input  logic active_on,
    input  logic field_swap,
    output logic vblank_o,
    output logic burst_en_o,
    output logic active_en_o,
    output logic caption_en_o,
    output logic field_o
);
    localparam int LINE_W  = $clog2(LINES + 1);
    localparam int N_SYNC  = 2;

    logic [N_SYNC-1:0] sync_w, pol_w, edge_w;
    logic [LINE_W-1:0] line_next;
    gate_cfg_t         cfg;
    gate_flags_t       dec_flags;
    gate_flags_t       flags_d, flags_q;

    assign sync_w = {vsync_in, hsync_in};
    assign pol_w  = {vs_pol, hs_pol};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_edge
        ntsc_sync_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .sync_in(sync_w[g]),
            .pol    (pol_w[g]),
            .edge_o (edge_w[g])
        );
    end

    ntsc_line_track #(
        .LINES    (LINES),
        .F1_LINES (F1_LINES),
        .HALF_LINE(HALF_LINE),
        .LINE_W   (LINE_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .hs_edge    (edge_w[0]),
        .vs_edge    (edge_w[1]),
        .line_next_o(line_next)
    );

    always_comb begin
        cfg.wide_blank = wide_blank;
        cfg.cap_f1_en  = cap_f1_en;
        cfg.cap_f2_en  = cap_f2_en;
        cfg.cap_all    = cap_all;
        cfg.active_on  = active_on;
        cfg.burst_on   = burst_on;
        cfg.field_swap = field_swap;
    end

    ntsc_line_decode #(
        .F1_LINES  (F1_LINES),
        .NARROW_VB (NARROW_VB),
        .WIDE_VB   (WIDE_VB),
        .CAP_LINE_1(CAP_LINE_1),
        .CAP_LINE_2(CAP_LINE_2),
        .LINE_W    (LINE_W)
    ) u_decode (
        .line_i (line_next),
        .cfg_i  (cfg),
        .flags_o(dec_flags)
    );

    always_comb begin
        flags_d = edge_w[0] ? dec_flags : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign vblank_o     = flags_q.vblank;
    assign burst_en_o   = flags_q.burst;
    assign active_en_o  = flags_q.active;
    assign caption_en_o = flags_q.caption;
    assign field_o      = flags_q.field;
endmodule

// File: rtl/ntsc_line_gate_chk.sv
module ntsc_line_gate_chk (
    input logic clk,
    input logic rst,
    input logic hsync_in,
    input logic hs_pol,
    input logic burst_on,
    input logic vblank_o,
    input logic burst_en_o,
    input logic active_en_o,
    input logic caption_en_o,
    input logic field_o
);
    logic hs_prev_q;
    logic bo_seen_q;
    logic hs_act;

    assign hs_act = hs_pol ? (hsync_in & ~hs_prev_q) : (~hsync_in & hs_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev_q <= 1'b0;
            bo_seen_q <= 1'b0;
        end else begin
            hs_prev_q <= hsync_in;
            if (hs_act) bo_seen_q <= burst_on;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ({vblank_o, burst_en_o, active_en_o, caption_en_o, field_o} == 5'b0)); // R1

    AST_HOLD_WITHIN_LINE: assert property (@(posedge clk) disable iff (rst)
        !hs_act |=> $stable({vblank_o, burst_en_o, active_en_o, caption_en_o, field_o})); // R9

    AST_BLANK_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        vblank_o |-> !active_en_o); // R5

    AST_BLANK_BURST_FORCED: assert property (@(posedge clk) disable iff (rst)
        (vblank_o && burst_en_o) |-> bo_seen_q); // R6
endmodule

bind ntsc_line_gate ntsc_line_gate_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .hsync_in    (hsync_in),
    .hs_pol      (hs_pol),
    .burst_on    (burst_on),
    .vblank_o    (vblank_o),
    .burst_en_o  (burst_en_o),
    .active_en_o (active_en_o),
    .caption_en_o(caption_en_o),
    .field_o     (field_o)
);

// File: tb/ntsc_line_gate_tb_top.sv
module ntsc_line_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_CYC   = 16;
    localparam int HALF       = 8;
    localparam int VS_EARLY   = 3;
    localparam int VS_LATE    = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_in = 1'b0, vsync_in = 1'b0;
    logic hs_pol = 1'b1, vs_pol = 1'b1;
    logic wide_blank = 0, cap_f1_en = 0, cap_f2_en = 0, cap_all = 0;
    logic burst_on = 0, active_on = 0, field_swap = 0;
    logic vblank_o, burst_en_o, active_en_o, caption_en_o, field_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int   line;
        logic vb, bu, ac, ca, fi;
    } exp_t;
    exp_t sb_q[$];

    int m_line = 0;
    bit m_pend = 0;
    bit m_late = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntsc_line_gate #(.HALF_LINE(HALF)) dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .wide_blank(wide_blank),
        .cap_f1_en(cap_f1_en), .cap_f2_en(cap_f2_en), .cap_all(cap_all),
        .burst_on(burst_on), .active_on(active_on), .field_swap(field_swap),
        .vblank_o(vblank_o), .burst_en_o(burst_en_o), .active_en_o(active_en_o),
        .caption_en_o(caption_en_o), .field_o(field_o)
    );

    task automatic chk(input string tag, input int line, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s line=%0d actual=%b expected=%b", tag, line, got, exp);
        end
    endtask

    function automatic exp_t model(input int line);
        exp_t e;
        bit f2, blank;
        int fl;
        f2    = (line > 262);
        fl    = f2 ? line - 262 : line;
        blank = (fl <= (wide_blank ? 15 : 9));
        e.line = line;
        e.vb = !active_on && blank;                        // R4
        e.ac = active_on || !blank;                        // R5
        e.bu = active_on ? 1'b0 : (burst_on || !blank);    // R6
        e.ca = cap_all || (cap_f1_en && line == 21)
                       || (cap_f2_en && line == 284);      // R7
        e.fi = f2 ^ field_swap;                            // R3
        return e;
    endfunction

    // Driver: one line, optional vertical strobe early or late in the line (R2, R8)
    task automatic run_line(input bit do_vs, input bit late);
        @(negedge clk) hsync_in = hs_pol;
        @(posedge clk);
        if (m_pend) begin
            m_line = m_late ? 263 : 1;
            m_pend = 0;
        end else begin
            m_line = (m_line == 525) ? 1 : m_line + 1;
        end
        sb_q.push_back(model(m_line));
        @(negedge clk) hsync_in = ~hs_pol;
        for (int k = 2; k < LINE_CYC; k++) begin
            @(negedge clk);
            vsync_in = (do_vs && k == (late ? VS_LATE : VS_EARLY)) ? vs_pol : ~vs_pol;
        end
        if (do_vs) begin
            m_pend = 1;
            m_late = late;
        end
    endtask

    task automatic run_lines(input int n, input bit vs_last, input bit late);
        for (int i = 0; i < n; i++) run_line(vs_last && i == n - 1, late);
    endtask

    task automatic do_reset(input logic hp, input logic vp);
        @(negedge clk);
        rst = 1'b1;
        hs_pol = hp; vs_pol = vp;
        hsync_in = ~hp; vsync_in = ~vp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_line = 0; m_pend = 0; m_late = 0;
        repeat (2) @(negedge clk);
        chk("R1 vblank", 0, vblank_o, 1'b0);
        chk("R1 burst", 0, burst_en_o, 1'b0);
        chk("R1 active", 0, active_en_o, 1'b0);
        chk("R1 caption", 0, caption_en_o, 1'b0);
        chk("R1 field", 0, field_o, 1'b0);
    endtask

    // Monitor: pops the expected item for each line and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4 vblank", e.line, vblank_o, e.vb);
                chk("R5 active", e.line, active_en_o, e.ac);
                chk("R6 burst", e.line, burst_en_o, e.bu);
                chk("R7 caption", e.line, caption_en_o, e.ca);
                chk("R3/R2 field", e.line, field_o, e.fi);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1'b1, 1'b1);

        // Narrow blanking, caption on line 21; free-running count then sync (R2, R4, R7)
        cap_f1_en = 1;
        run_lines(3, 0, 0);
        run_line(1, 0);
        run_lines(262, 1, 1);          // field 1, strobe late -> line 263
        run_lines(263, 0, 0);          // field 2, ends at 525
        run_line(0, 0);                // wrap 525 -> 1 (R2)
        run_line(1, 0);                // line 2, early strobe -> line 1

        // Wide blanking, caption on line 284, field swap (R3, R4, R7)
        wide_blank = 1; cap_f1_en = 0; cap_f2_en = 1; field_swap = 1;
        run_lines(262, 1, 1);
        run_lines(263, 1, 0);

        // Caption on every line, burst forced on blanked lines (R6, R7)
        wide_blank = 0; cap_f2_en = 0; field_swap = 0; cap_all = 1; burst_on = 1;
        run_lines(20, 0, 0);

        // Mid-line change has no effect until the next edge (R9)
        @(negedge clk) cap_all = 0;
        @(negedge clk);
        chk("R9 caption held", m_line, caption_en_o, 1'b1);
        run_line(0, 0);

        // Blanking removed, burst suppressed even with burst_on (R5, R6)
        active_on = 1;
        run_lines(10, 0, 0);
        active_on = 0; burst_on = 0;

        // Falling-edge sync polarity, field 2 start by late strobe (R8)
        do_reset(1'b0, 1'b0);
        run_lines(2, 1, 1);
        run_lines(20, 0, 0);
        run_lines(1, 0, 0);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule